// File: doc/BRIEF.md
# Clock Root Selector with Half-Step Divider

This block is a programmable clock root. It picks one of several source clocks and divides the chosen one by a ratio that can land on half-integer steps. The output rate is the source rate times two, divided by the divider field plus one. Each source arrives as a one-cycle strobe on a single fast reference clock, and the output leaves as a one-cycle enable pulse on that same clock. For ratios that are not whole numbers, successive output periods alternate between two lengths, so the long-run rate is exact.

Software reaches the block through two 32-bit words. The configuration word at byte offset 0x4 holds the source index and the divider field. Writing it only stages the new values. They become live when software sets the request bit (bit 0) of the command word at offset 0x0. The hardware then switches over at the next output period boundary and clears the request bit itself. If the current root is not running, the switch happens at once instead.

The command word also reports two things. Bit 4 shows staged values that have not yet been committed. Bit 31 shows that the root output is stopped.

Top module: `clk_root_mux_div`

## Requirements
- R1: After reset the command word reads 0 (with the active source running), and the configuration word reads the divider field set to 1 and every other bit 0. Source 0 is active at divide-by-one.
- R2: A write to the configuration word stores all 32 bits, and a read returns the stored word. The active source and divider do not change until a commit.
- R3: Command bit 4 reads 1 from the cycle after any configuration write until the commit that follows it, and then reads 0.
- R4: Writing the command word with bit 0 set makes bit 0 read 1. Writing bit 0 as 0, or setting any other bit, leaves bit 0, bit 4 and bit 31 unchanged.
- R5: A pending request commits only in a cycle that ends an output period (an output pulse with no second pulse still owed), or in any cycle in which the active root is stopped. Bit 0 reads 0 from the next cycle.
- R6: With divider field D active, k strobes of the active source after a commit give exactly floor(2k/(D+1)) output pulses. This holds for D = 0, where each strobe gives two pulses in consecutive cycles (strobes must be at least two reference cycles apart), and for the all-ones field.
- R7: Strobes on any source other than the active one produce no output pulses.
- R8: Command bit 31 reads 1 when the active source's running input is low, or when the active index is not below the number of sources. While it is 1, no output pulses appear.
- R9: A commit clears the divider's phase, so the first period under the new ratio is a full one, whatever remainder the old ratio left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset: 0x0 command, 0x4 configuration |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational), 0 for other offsets |
| src_tick | input | NUM_SRC | One-cycle strobe per source clock edge |
| src_ok | input | NUM_SRC | High while the matching source is running |
| out_en | output | 1 | Divided output enable pulse |

## Verification
The bench builds the block with three sources and a 3-bit source field. Indices 3 to 7 can then be written, which exercises the stopped-root reporting for an out-of-range selection. The divider field is 4 bits wide at bit 4 and the source field sits at bit 12, so both fields are off bit 0 and surrounded by bits that must be kept. The all-ones divider (ratio 8) stays short enough to count through its full period, which is what pins down the boundary-only commit. Both the odd and the even half-step ratios, as well as the doubling field 0, are reached by table vectors.

// File: rtl/mdv_pkg.sv
package mdv_pkg;

  localparam int unsigned CMD_OFS   = 0;
  localparam int unsigned CFG_OFS   = 4;
  localparam int unsigned UPD_BIT   = 0;
  localparam int unsigned DIRTY_BIT = 4;
  localparam int unsigned OFF_BIT   = 31;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CMD  = 2'd1,
    SEL_CFG  = 2'd2
  } reg_sel_e;

  // Pack the command word from its three live bits.
  function automatic logic [31:0] pack_cmd(input logic upd, input logic dirty,
                                           input logic off);
    logic [31:0] w;
    w = '0;
    w[UPD_BIT]   = upd;
    w[DIRTY_BIT] = dirty;
    w[OFF_BIT]   = off;
    return w;
  endfunction

  // Denominator of the output ratio 2/(field+1).
  function automatic int unsigned ratio_den(input int unsigned fld);
    return fld + 1;
  endfunction

endpackage

// File: rtl/mdv_regs.sv
module mdv_regs
  import mdv_pkg::*;
#(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned SRC_POS = 8,
  parameter int unsigned SRC_W   = 3,
  parameter int unsigned DIV_POS = 0,
  parameter int unsigned DIV_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              commit,
  input  logic              root_off,
  output logic [SRC_W-1:0]  stg_src,
  output logic [DIV_W-1:0]  stg_div,
  output logic              upd_q,
  output logic              upd_set
);

  localparam logic [31:0] CFG_RST = 32'd1 << DIV_POS;

  reg_sel_e    sel;
  logic        cfg_wr;
  logic        dirty_q;
  logic [31:0] cfg_q;

  always_comb begin
    if (reg_addr == ADDR_W'(CMD_OFS))      sel = SEL_CMD;
    else if (reg_addr == ADDR_W'(CFG_OFS)) sel = SEL_CFG;
    else                                   sel = SEL_NONE;
  end

  assign cfg_wr  = reg_we && (sel == SEL_CFG);
  assign upd_set = reg_we && (sel == SEL_CMD) && reg_wdata[UPD_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RST;
      upd_q   <= 1'b0;
      dirty_q <= 1'b0;
    end else begin
      if (cfg_wr) cfg_q <= reg_wdata;
      if (upd_set)     upd_q <= 1'b1;
      else if (commit) upd_q <= 1'b0;
      if (cfg_wr)      dirty_q <= 1'b1;
      else if (commit) dirty_q <= 1'b0;
    end
  end

  assign stg_src = cfg_q[SRC_POS +: SRC_W];
  assign stg_div = cfg_q[DIV_POS +: DIV_W];

  always_comb begin
    case (sel)
      SEL_CMD: reg_rdata = pack_cmd(upd_q, dirty_q, root_off);
      SEL_CFG: reg_rdata = cfg_q;
      default: reg_rdata = '0;
    endcase
  end

  assert_dirty_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> dirty_q);
  assert_upd_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !upd_set) |=> !upd_q);
  assert_upd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_q && !commit) |=> upd_q);

endmodule

// File: rtl/mdv_src_sel.sv
module mdv_src_sel #(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned SRC_W   = 3
) (
  input  logic [SRC_W-1:0]   act_src,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic [NUM_SRC-1:0] src_ok,
  output logic               tick_sel,
  output logic               running
);

  logic [NUM_SRC-1:0] hit;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
    assign hit[i] = (act_src == SRC_W'(i));
  end

  assign running  = |(hit & src_ok);
  assign tick_sel = |(hit & src_ok & src_tick);

endmodule

// File: rtl/mdv_frac_div.sv
module mdv_frac_div #(
  parameter int unsigned DIV_W = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_in,
  input  logic [DIV_W:0] den,
  input  logic           restart,
  output logic           out_en,
  output logic           boundary
);

  localparam int unsigned SUM_W = DIV_W + 2;

  logic [DIV_W:0]   acc_q, acc_n;
  logic             extra_q, extra_n;
  logic             pulse;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] den_x;

  assign den_x = SUM_W'(den);

  always_comb begin
    pulse   = extra_q;
    extra_n = 1'b0;
    sum     = SUM_W'(acc_q);
    if (tick_in) begin
      sum = SUM_W'(acc_q) + SUM_W'(2);
      if (sum >= den_x) begin
        sum = sum - den_x;
        if (pulse) extra_n = 1'b1;
        else       pulse   = 1'b1;
        if (sum >= den_x) begin
          sum     = sum - den_x;
          extra_n = 1'b1;
        end
      end
    end
    acc_n = sum[DIV_W:0];
  end

  assign boundary = pulse && !extra_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      extra_q <= 1'b0;
      out_en  <= 1'b0;
    end else begin
      out_en <= pulse;
      if (restart) begin
        acc_q   <= '0;
        extra_q <= 1'b0;
      end else begin
        acc_q   <= acc_n;
        extra_q <= extra_n;
      end
    end
  end

  assert_pulse_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> $past(tick_in || extra_q));
  assert_extra_only_den1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    extra_q |-> $past(den == (DIV_W+1)'(1)));
  assert_phase_below_den_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(restart) |-> (acc_q == '0));

endmodule

// File: rtl/clk_root_mux_div.sv
module clk_root_mux_div
  import mdv_pkg::*;
#(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned SRC_W   = 3,
  parameter int unsigned SRC_POS = 8,
  parameter int unsigned DIV_W   = 5,
  parameter int unsigned DIV_POS = 0
) (
  input  logic               clk_ref,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic [NUM_SRC-1:0] src_ok,
  output logic               out_en
);

  logic [SRC_W-1:0] stg_src, act_src;
  logic [DIV_W-1:0] stg_div, act_div;
  logic [DIV_W:0]   den;
  logic             upd_q, upd_set;
  logic             tick_sel, running, root_off;
  logic             boundary, commit;

  assign root_off = !running;
  assign commit   = upd_q && (boundary || root_off);
  assign den      = (DIV_W+1)'(ratio_den(32'(act_div)));

  mdv_regs #(
    .ADDR_W (ADDR_W), .SRC_POS(SRC_POS), .SRC_W(SRC_W),
    .DIV_POS(DIV_POS), .DIV_W(DIV_W)
  ) regs_i (
    .clk(clk_ref), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .commit(commit),
    .root_off(root_off), .stg_src(stg_src), .stg_div(stg_div),
    .upd_q(upd_q), .upd_set(upd_set)
  );

  mdv_src_sel #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) sel_i (
    .act_src(act_src), .src_tick(src_tick), .src_ok(src_ok),
    .tick_sel(tick_sel), .running(running)
  );

  mdv_frac_div #(.DIV_W(DIV_W)) div_i (
    .clk(clk_ref), .rst_n(rst_n), .tick_in(tick_sel), .den(den),
    .restart(commit), .out_en(out_en), .boundary(boundary)
  );

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      act_src <= '0;
      act_div <= DIV_W'(1);
    end else if (commit) begin
      act_src <= stg_src;
      act_div <= stg_div;
    end
  end

  assert_active_on_commit_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!$stable(act_src) || !$stable(act_div)) |-> $past(commit));
  assert_commit_at_edge_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $past(upd_q && !upd_set) && !upd_q |-> $past(boundary || !running));
  assert_off_no_pulse_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ($past(!running) && $past(!out_en) && !$past(boundary)) |-> !out_en);

endmodule

// File: tb/clk_root_mux_div_tb_top.sv
`timescale 1ns/1ps
module clk_root_mux_div_tb_top;

  localparam int NS  = 3;
  localparam int SW  = 3;
  localparam int SP  = 12;
  localparam int DW  = 4;
  localparam int DP  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NS-1:0] src_tick = '0;
  logic [NS-1:0] src_ok = '1;
  logic          out_en;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int cur_src = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  clk_root_mux_div #(.ADDR_W(3), .NUM_SRC(NS), .SRC_W(SW), .SRC_POS(SP),
                     .DIV_W(DW), .DIV_POS(DP)) dut_i (
    .clk_ref(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_tick(src_tick),
    .src_ok(src_ok), .out_en(out_en)
  );

  always @(negedge clk) if (out_en) pulses <= pulses + 1;

  // {src, div, ticks}
  localparam int NV = 6;
  localparam int VEC [NV][3] = '{
    '{0, 1, 6}, '{1, 2, 5}, '{2, 4, 7}, '{1, 0, 4}, '{0, 15, 17}, '{2, 6, 9}
  };

  function automatic int exp_pulses(input int d, input int k);
    int n = 0;
    for (int j = 1; j <= k; j++)
      if (((2 * j) / (d + 1)) != ((2 * (j - 1)) / (d + 1))) n += (2 * j) / (d + 1) - (2 * (j - 1)) / (d + 1);
    return n;
  endfunction

  function automatic logic [31:0] cfg_word(input int s, input int d, input logic [31:0] extra);
    return extra | (32'(s) << SP) | (32'(d) << DP);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic tick(input int s);
    @(negedge clk);
    src_tick[s] = 1'b1;
    @(negedge clk);
    src_tick = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic ticks_count(input int s, input int k, output int n);
    int p0 = pulses;
    for (int j = 0; j < k; j++) tick(s);
    @(negedge clk);
    n = pulses - p0;
  endtask

  // Request a commit and tick the active source until the request clears.
  task automatic do_commit(input int new_src);
    logic [31:0] v;
    wr(3'h0, 32'h1);
    for (int j = 0; j < 40; j++) begin
      rd(3'h0, v);
      if (!v[0]) break;
      if (cur_src < NS) tick(cur_src);
    end
    rd(3'h0, v);
    check("R5 request cleared", 32'(v[0]), 32'd0);
    cur_src = new_src;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'h0, v); check("R1 command word", v, 32'h0);
    rd(3'h4, v); check("R1 config word", v, 32'h10);
    ticks_count(0, 3, n); check("R1 divide by one", 32'(n), 32'd3);

    // Vector table: R6 ratios, R7 other sources ignored, R2 full-word readback
    for (int i = 0; i < NV; i++) begin
      wr(3'h4, cfg_word(VEC[i][0], VEC[i][1], 32'h8001_0002));
      rd(3'h4, v); check("R2 readback", v, cfg_word(VEC[i][0], VEC[i][1], 32'h8001_0002));
      rd(3'h0, v); check("R3 dirty set", 32'(v[4]), 32'd1);
      do_commit(VEC[i][0]);
      rd(3'h0, v); check("R3 dirty cleared", 32'(v[4]), 32'd0);
      ticks_count(VEC[i][0], VEC[i][2], n);
      check("R6 pulse count", 32'(n), 32'(exp_pulses(VEC[i][1], VEC[i][2])));
      ticks_count((VEC[i][0] + 1) % NS, 3, n);
      check("R7 other source", 32'(n), 32'd0);
    end
    // active: src 2, div 6 (den 7), 9 ticks consumed -> move to known phase
    wr(3'h4, cfg_word(0, 15, 0)); do_commit(0);

    // R5: den 16 -> boundary every 8 ticks; staged change waits for it
    wr(3'h4, cfg_word(1, 1, 0));
    wr(3'h0, 32'h1);
    for (int j = 0; j < 7; j++) tick(0);
    rd(3'h0, v); check("R5 still pending before boundary", 32'(v[0]), 32'd1);
    ticks_count(1, 2, n); check("R2 staged source not yet live", 32'(n), 32'd0);
    tick(0);
    rd(3'h0, v); check("R5 cleared at boundary", 32'(v[0]), 32'd0);
    cur_src = 1;

    // R4: writing 0 to bit 0 with other bits set changes nothing
    wr(3'h4, cfg_word(1, 2, 0));
    wr(3'h0, 32'h1);
    wr(3'h0, 32'hFFFF_FFFE);
    rd(3'h0, v); check("R4 command bits kept", v, 32'h11);
    do_commit(1);

    // R9: den 3 leaves remainder 1 at first pulse; commit to den 5 restarts phase
    wr(3'h4, cfg_word(1, 4, 0));
    wr(3'h0, 32'h1);
    tick(1); tick(1);
    rd(3'h0, v); check("R5 commit on first pulse", 32'(v[0]), 32'd0);
    ticks_count(1, 2, n); check("R9 no early pulse", 32'(n), 32'd0);
    ticks_count(1, 1, n); check("R9 full first period", 32'(n), 32'd1);

    // R8: stopped source reports off, gives no pulses, commits at once
    src_ok[1] = 1'b0;
    rd(3'h0, v); check("R8 off bit", 32'(v[31]), 32'd1);
    ticks_count(1, 4, n); check("R8 no pulses when off", 32'(n), 32'd0);
    wr(3'h4, cfg_word(0, 1, 0));
    wr(3'h0, 32'h1);
    repeat (2) @(negedge clk);
    rd(3'h0, v); check("R5 immediate commit when off", v, 32'h0);
    cur_src = 0;
    src_ok[1] = 1'b1;
    wr(3'h4, cfg_word(5, 1, 0)); do_commit(5);
    rd(3'h0, v); check("R8 out of range index off", 32'(v[31]), 32'd1);
    ticks_count(0, 2, n); check("R8 out of range no pulses", 32'(n), 32'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule